// File: doc/BRIEF.md
# IR pulse/space sample capture

This block turns the demodulated output of an infrared receiver into a stream of one-byte run-length samples. A programmable sample period, counted in microseconds, is derived from the system clock. On each sample strike the synchronised input level is compared with the level of the run in progress. When the level changes, the run is closed and stored as a sample. Each sample holds a space flag and a 7-bit duration measured in sample periods. A run that lasts too long is split into saturated overflow samples of the same polarity.

Samples are written into an eight-byte ping-pong buffer made of two halves of four bytes. Each time a half fills, the block records which half is ready and raises a pending flag. The interrupt output follows the pending flags while interrupts are enabled. Software reads the ready half and writes a clear bit. The period register can also raise an interrupt whenever a sample saturates at the overflow code.

A separate meter counts 500 ns ticks between consecutive rising edges of the raw input. It reports that count as the carrier period, together with a valid flag. The flag drops when no rising edge arrives within the counter's range. All settings and results sit behind a small register-style port with a write strobe and a combinational read.

Top module: `irc_capture`

## Requirements
- R1: After reset, control (address 0x0) reads 0x00, period (0x1) reads 0x32, status (0x2) reads 0x00, carrier (0x3) reads 0x00, buffer bytes (0x8 to 0xF) read 0x00, and irq is low.
- R2: A sample byte has bit 7 set when the run was a space (ir_in low) and clear for a pulse (ir_in high). Bits 6:0 hold the number of sample strikes the run lasted. A sample is emitted when the level changes, and the new run starts counting at 1.
- R3: When a run reaches 127 strikes, a sample with duration 0x7F and the run's polarity is emitted and counting restarts. A level change emits no sample if nothing has been counted since that overflow sample.
- R4: Samples are stored in order at buffer addresses 0x8 to 0xF and wrap after the eighth. After the fourth sample of a half, status bit 0 gives that half (0 for bytes 0x8 to 0xB, 1 for 0xC to 0xF) and status bit 1 (half pending) is set.
- R5: irq equals control bit 1 AND (status bit 1 OR status bit 2). Writing status with bit 1 set clears the half pending flag, and writing it with bit 2 set clears the overflow pending flag.
- R6: Status bit 2 (overflow pending) is set by an overflow sample only while period register bit 7 is set.
- R7: While control bit 0 (receive enable) is clear, no samples are stored and no pending flag is set. Enabling starts a fresh run, whose first strike counts as 1.
- R8: Carrier register bits 6:0 hold the count of 500 ns ticks between the last two rising edges of ir_in, and bit 7 is set once two such edges have been seen. Bit 7 clears after 127 ticks pass with no rising edge.
- R9: Sample strikes are spaced by period register bits 6:0 microseconds, with a value of 0 treated as 1, so durations scale with the programmed period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_in | input | 1 | Demodulated receiver level, high while carrier is present |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the alignment between input edges and sample strikes. An edge that lands near a strike makes the duration ambiguous. The bench therefore starts each pattern half a sample period after the enable write lands, and it holds every level for a whole number of periods, so each run covers an exact count of strikes. Runs of 127, 130 and 254 periods drive the overflow split and the empty close that follows it. Long random patterns wrap the ping-pong buffer past both halves.

// File: rtl/irc_pkg.sv
package irc_pkg;

    localparam int DUR_W = 7;
    localparam logic [DUR_W-1:0] DUR_MAX  = '1;
    localparam logic [DUR_W-1:0] DUR_PRE  = DUR_MAX - DUR_W'(1);
    localparam logic [DUR_W-1:0] DUR_ONE  = DUR_W'(1);

    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] A_CTRL    = 4'h0;
    localparam logic [ADDR_W-1:0] A_PERIOD  = 4'h1;
    localparam logic [ADDR_W-1:0] A_STATUS  = 4'h2;
    localparam logic [ADDR_W-1:0] A_CARRIER = 4'h3;
    localparam int BUF_SEL_BIT = 3;

    localparam logic [7:0] PERIOD_RST = 8'h32;

    typedef struct packed {
        logic             space;
        logic [DUR_W-1:0] dur;
    } sample_t;

    typedef struct packed {
        logic irq_en;
        logic rx_en;
    } ctrl_t;

    function automatic sample_t make_sample(input logic lvl, input logic [DUR_W-1:0] d);
        sample_t s;
        s.space = ~lvl;
        s.dur   = d;
        return s;
    endfunction

endpackage

// File: rtl/irc_timebase.sv
module irc_timebase #(
    parameter int HALF_US_CYC = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [6:0] period_us,
    output logic       half_tick,
    output logic       strobe
);
    localparam int HW = (HALF_US_CYC > 1) ? $clog2(HALF_US_CYC) : 1;
    localparam logic [HW-1:0] HLAST = HW'(HALF_US_CYC - 1);

    logic [HW-1:0] hcnt;
    logic          uphase;
    logic [6:0]    pcnt;
    logic [6:0]    plimit;
    logic          us_tick;

    assign plimit    = (period_us == 7'd0) ? 7'd1 : period_us;
    assign half_tick = run && (hcnt == HLAST);
    assign us_tick   = half_tick && uphase;
    assign strobe    = us_tick && (pcnt >= plimit - 7'd1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hcnt   <= '0;
            uphase <= 1'b0;
            pcnt   <= '0;
        end else begin
            hcnt <= half_tick ? '0 : hcnt + HW'(1);
            if (half_tick) uphase <= ~uphase;
            if (us_tick)   pcnt   <= strobe ? 7'd0 : pcnt + 7'd1;
        end
    end
endmodule

// File: rtl/irc_run_encoder.sv
module irc_run_encoder
    import irc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    input  logic    strobe,
    input  logic    din,
    output logic    emit,
    output sample_t sample,
    output logic    ovf
);
    logic             active;
    logic             level;
    logic [DUR_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            active <= 1'b0;
            level  <= 1'b0;
            cnt    <= '0;
            emit   <= 1'b0;
            ovf    <= 1'b0;
            sample <= '0;
        end else begin
            emit <= 1'b0;
            ovf  <= 1'b0;
            if (strobe) begin
                if (!active) begin
                    active <= 1'b1;
                    level  <= din;
                    cnt    <= DUR_ONE;
                end else if (din != level) begin
                    // close the run unless an overflow sample just consumed it
                    if (cnt != '0) begin
                        emit   <= 1'b1;
                        sample <= make_sample(level, cnt);
                    end
                    level <= din;
                    cnt   <= DUR_ONE;
                end else if (cnt == DUR_PRE) begin
                    emit   <= 1'b1;
                    ovf    <= 1'b1;
                    sample <= make_sample(level, DUR_MAX);
                    cnt    <= '0;
                end else begin
                    cnt <= cnt + DUR_ONE;
                end
            end
        end
    end
endmodule

// File: rtl/irc_sample_buffer.sv
module irc_sample_buffer
    import irc_pkg::*;
#(
    parameter int HALF_DEPTH = 4,
    localparam int DEPTH = 2 * HALF_DEPTH,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  sample_t          wdata,
    input  logic [PTR_W-1:0] rd_idx,
    output sample_t          rd_data,
    output logic             half_done,
    output logic             done_half
);
    localparam int OFF_W = $clog2(HALF_DEPTH);

    sample_t          mem [DEPTH];
    logic [PTR_W-1:0] wp;
    logic             last_slot;

    assign last_slot = (wp[OFF_W-1:0] == '1);
    assign rd_data   = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp        <= '0;
            half_done <= 1'b0;
            done_half <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            half_done <= 1'b0;
            if (wr) begin
                mem[wp] <= wdata;
                wp      <= wp + PTR_W'(1);
                if (last_slot) begin
                    half_done <= 1'b1;
                    done_half <= wp[PTR_W-1];
                end
            end
        end
    end
endmodule

// File: rtl/irc_carrier_meter.sv
module irc_carrier_meter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             din,
    input  logic             tick,
    output logic             valid,
    output logic [CNT_W-1:0] value
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic             din_q;
    logic             seen;
    logic             rise;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;

    assign rise   = run && din && !din_q;
    assign cnt_nx = (tick && cnt != CMAX) ? cnt + CNT_W'(1) : cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            din_q <= 1'b0;
            seen  <= 1'b0;
            cnt   <= '0;
            valid <= 1'b0;
            value <= '0;
        end else begin
            din_q <= din;
            if (!run) begin
                cnt  <= '0;
                seen <= 1'b0;
            end else if (rise) begin
                if (seen) begin
                    valid <= 1'b1;
                    value <= cnt_nx;
                end
                seen <= 1'b1;
                cnt  <= '0;
            end else if (cnt_nx == CMAX) begin
                valid <= 1'b0;
                seen  <= 1'b0;
                cnt   <= cnt_nx;
            end else begin
                cnt <= cnt_nx;
            end
        end
    end
endmodule

// File: rtl/irc_capture.sv
module irc_capture
    import irc_pkg::*;
#(
    parameter int HALF_US_CYC = 100,
    parameter int HALF_DEPTH  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ir_in,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [3:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       irq
);
    localparam int PTR_W = $clog2(2 * HALF_DEPTH);

    logic       ir_q1, ir_q2;
    ctrl_t      ctrl;
    logic [7:0] per_reg;
    logic       ready_half, rx_pend, ovf_pend;
    logic       clr_rx, clr_ovf;
    logic       half_tick, strobe;
    logic       enc_emit, enc_ovf;
    sample_t    enc_sample;
    sample_t    buf_rd;
    logic       half_done, done_half;
    logic       car_valid;
    logic [6:0] car_value;

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q1 <= 1'b0;
            ir_q2 <= 1'b0;
        end else begin
            ir_q1 <= ir_in;
            ir_q2 <= ir_q1;
        end
    end

    irc_timebase #(.HALF_US_CYC(HALF_US_CYC)) u_tb (
        .clk(clk), .rst(rst), .run(ctrl.rx_en), .period_us(per_reg[6:0]),
        .half_tick(half_tick), .strobe(strobe)
    );

    irc_run_encoder u_enc (
        .clk(clk), .rst(rst), .run(ctrl.rx_en), .strobe(strobe), .din(ir_q2),
        .emit(enc_emit), .sample(enc_sample), .ovf(enc_ovf)
    );

    irc_sample_buffer #(.HALF_DEPTH(HALF_DEPTH)) u_buf (
        .clk(clk), .rst(rst), .wr(enc_emit), .wdata(enc_sample),
        .rd_idx(rd_addr[PTR_W-1:0]), .rd_data(buf_rd),
        .half_done(half_done), .done_half(done_half)
    );

    irc_carrier_meter #(.CNT_W(7)) u_car (
        .clk(clk), .rst(rst), .run(ctrl.rx_en), .din(ir_q2), .tick(half_tick),
        .valid(car_valid), .value(car_value)
    );

    assign clr_rx  = wr_en && (wr_addr == A_STATUS) && wr_data[1];
    assign clr_ovf = wr_en && (wr_addr == A_STATUS) && wr_data[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl       <= '0;
            per_reg    <= PERIOD_RST;
            ready_half <= 1'b0;
            rx_pend    <= 1'b0;
            ovf_pend   <= 1'b0;
        end else begin
            if (wr_en && wr_addr == A_CTRL)   ctrl    <= ctrl_t'(wr_data[1:0]);
            if (wr_en && wr_addr == A_PERIOD) per_reg <= wr_data;
            if (half_done) begin
                rx_pend    <= 1'b1;
                ready_half <= done_half;
            end else if (clr_rx) begin
                rx_pend <= 1'b0;
            end
            if (enc_ovf && per_reg[7]) ovf_pend <= 1'b1;
            else if (clr_ovf)          ovf_pend <= 1'b0;
        end
    end

    assign irq = ctrl.irq_en && (rx_pend || ovf_pend);

    always_comb begin
        rd_data = '0;
        if (rd_addr[BUF_SEL_BIT]) begin
            rd_data = buf_rd;
        end else begin
            case (rd_addr)
                A_CTRL:    rd_data = {6'b0, ctrl};
                A_PERIOD:  rd_data = per_reg;
                A_STATUS:  rd_data = {5'b0, ovf_pend, rx_pend, ready_half};
                A_CARRIER: rd_data = {car_valid, car_value};
                default:   rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/irc_capture_chk.sv
module irc_capture_chk (
    input logic       clk,
    input logic       rst,
    input logic       emit,
    input logic [6:0] dur,
    input logic       ovf_emit,
    input logic       half_done,
    input logic       rx_pend,
    input logic       ovf_pend,
    input logic       ovf_en,
    input logic       rx_en,
    input logic       irq_en,
    input logic       clr_rx,
    input logic       irq
);
    p_dur_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
        emit |-> dur != 7'd0);

    p_ovf_code_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_emit |-> (emit && dur == 7'h7F));

    p_pend_set_r4: assert property (@(posedge clk) disable iff (rst)
        half_done |=> rx_pend);

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_rx && !half_done) |=> !rx_pend);

    p_irq_off_r5: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    p_ovf_gate_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_pend) |-> $past(ovf_emit && ovf_en));

    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !$past(rx_en)) |-> !emit);
endmodule

bind irc_capture irc_capture_chk u_chk (
    .clk(clk), .rst(rst), .emit(enc_emit), .dur(enc_sample.dur),
    .ovf_emit(enc_ovf), .half_done(half_done), .rx_pend(rx_pend),
    .ovf_pend(ovf_pend), .ovf_en(per_reg[7]), .rx_en(ctrl.rx_en),
    .irq_en(ctrl.irq_en), .clr_rx(clr_rx), .irq(irq)
);

// File: tb/tb_irc_capture.sv
`timescale 1ns/1ps
module tb_irc_capture;
    localparam int H = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ir_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq;

    irc_capture #(.HALF_US_CYC(H)) dut (
        .clk(clk), .rst(rst), .ir_in(ir_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #2.5 clk = ~clk;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 0;
    int   run_len [0:31];
    logic run_lvl [0:31];
    int   n_runs;
    logic [7:0] exp_s [0:63];
    int   n_exp;
    logic exp_ovf;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1; ir_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [7:0] enc(input logic lvl, input int n);
        return {~lvl, n[6:0]};
    endfunction

    task automatic build_expected(input logic ovf_en);
        n_exp = 0;
        exp_ovf = 1'b0;
        for (int k = 0; k < n_runs; k++) begin
            int l = run_len[k];
            while (l >= 127) begin
                exp_s[n_exp] = enc(run_lvl[k], 127);
                n_exp++;
                l -= 127;
                if (ovf_en) exp_ovf = 1'b1;
            end
            if (l > 0) begin
                exp_s[n_exp] = enc(run_lvl[k], l);
                n_exp++;
            end
        end
    endtask

    task automatic run_scenario(input int p, input logic ovf_en, input logic irq_en);
        int s;
        int nh;
        logic rh, exp_rx;
        logic [7:0] v;
        s = p * 2 * H;
        do_reset;
        wr(4'h1, {ovf_en, p[6:0]});
        ir_in = run_lvl[0];
        wr(4'h0, {6'b0, irq_en, 1'b1});
        repeat (s/2 - 1) @(negedge clk);
        for (int k = 0; k < n_runs; k++) begin
            ir_in = run_lvl[k];
            repeat (run_len[k] * s) @(negedge clk);
        end
        ir_in = ~run_lvl[n_runs-1];
        repeat (3 * s) @(negedge clk);
        build_expected(ovf_en);
        nh = n_exp / 4;
        rh = (nh == 0) ? 1'b0 : 1'(((nh - 1) % 2));
        exp_rx = (nh > 0);
        #1;
        check("R5 irq after pattern", irq, irq_en && (exp_rx || exp_ovf));
        wr(4'h0, {6'b0, irq_en, 1'b0});
        rd(4'h2, v);
        check("R4/R6 status", v, {5'b0, exp_ovf, exp_rx, rh});
        for (int i = 0; i < 8; i++) begin
            logic [7:0] e;
            e = 8'h00;
            if (i < n_exp) e = exp_s[i + 8 * ((n_exp - 1 - i) / 8)];
            rd(4'(8 + i), v);
            check($sformatf("R2/R3/R9 buffer byte %0d (P=%0d)", i, p), v, e);
        end
        wr(4'h2, 8'h06);
        rd(4'h2, v);
        check("R5 status after clear", v, {7'b0, rh});
        check("R5 irq after clear", irq, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int seed;
        seed = $urandom(32'd20240607);
        do_reset;

        // R1 reset state
        rd(4'h0, v); check("R1 control", v, 8'h00);
        rd(4'h1, v); check("R1 period", v, 8'h32);
        rd(4'h2, v); check("R1 status", v, 8'h00);
        rd(4'h3, v); check("R1 carrier", v, 8'h00);
        rd(4'h8, v); check("R1 buffer", v, 8'h00);
        check("R1 irq", irq, 1'b0);

        // R2 directed encoding, five samples fills half 0
        n_runs = 5;
        run_lvl[0] = 1; run_len[0] = 3;
        run_lvl[1] = 0; run_len[1] = 5;
        run_lvl[2] = 1; run_len[2] = 1;
        run_lvl[3] = 0; run_len[3] = 2;
        run_lvl[4] = 1; run_len[4] = 4;
        run_scenario(2, 1'b0, 1'b1);

        // R4 wrap past both halves
        n_runs = 10;
        for (int k = 0; k < 10; k++) begin
            run_lvl[k] = 1'(k % 2);
            run_len[k] = 2 + (k % 3);
        end
        run_scenario(2, 1'b0, 1'b1);

        // R3 / R6 overflow split with overflow interrupt enabled
        n_runs = 3;
        run_lvl[0] = 0; run_len[0] = 130;
        run_lvl[1] = 1; run_len[1] = 127;
        run_lvl[2] = 0; run_len[2] = 2;
        run_scenario(3, 1'b1, 1'b1);
        // R6 same pattern, overflow interrupt disabled
        run_scenario(3, 1'b0, 1'b1);
        // R3 double overflow of a pulse
        n_runs = 2;
        run_lvl[0] = 1; run_len[0] = 254;
        run_lvl[1] = 0; run_len[1] = 5;
        run_scenario(2, 1'b1, 1'b0);

        // R9 random patterns with periods 2 and 3
        for (int t = 0; t < 6; t++) begin
            logic l0;
            n_runs = 3 + int'($urandom % 9);
            l0 = 1'($urandom % 2);
            for (int k = 0; k < n_runs; k++) begin
                run_lvl[k] = l0 ^ 1'(k % 2);
                run_len[k] = 1 + int'($urandom % 24);
            end
            run_scenario(2 + (t % 2), 1'($urandom % 2), 1'($urandom % 2));
        end

        // R7 receiver disabled: activity is ignored
        do_reset;
        wr(4'h1, 8'h82);
        wr(4'h0, 8'h02);
        for (int k = 0; k < 40; k++) begin
            ir_in = ~ir_in;
            repeat (5) @(negedge clk);
        end
        rd(4'h2, v); check("R7 status while disabled", v, 8'h00);
        rd(4'h8, v); check("R7 buffer while disabled", v, 8'h00);
        rd(4'h3, v); check("R7 carrier while disabled", v, 8'h00);
        check("R7 irq while disabled", irq, 1'b0);

        // R8 carrier measurement
        do_reset;
        wr(4'h1, 8'h02);
        ir_in = 1'b0;
        wr(4'h0, 8'h01);
        for (int k = 0; k < 5; k++) begin
            ir_in = 1'b1; repeat (10) @(negedge clk);
            ir_in = 1'b0; repeat (10) @(negedge clk);
        end
        rd(4'h3, v); check("R8 carrier 10 ticks", v, 8'h8A);
        for (int k = 0; k < 4; k++) begin
            ir_in = 1'b1; repeat (7) @(negedge clk);
            ir_in = 1'b0; repeat (7) @(negedge clk);
        end
        rd(4'h3, v); check("R8 carrier 7 ticks", v, 8'h87);
        repeat (300) @(negedge clk);
        rd(4'h3, v); check("R8 carrier valid after timeout", v[7], 1'b0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule